// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Sequencer

This block walks a linked chain of transfer descriptors kept in a word-addressed descriptor memory. Each descriptor is three 32-bit words. The block reads the control word and the link word, launches the transfer on a data mover, and waits for the mover's done pulse. It then writes a completion status into the descriptor's status word and moves on along the link. When the final descriptor of a packet is retired, it raises a packet event toward the interrupt logic and increments a packet count.

Software drives the sequencer through a small write port that has three selectable registers: the live next-descriptor pointer, an enable bit and a live stop flag. A descriptor can carry its own stop request. The engine copies that request into the live stop flag and halts once that descriptor is finished. Software can then append descriptors behind the halted one and clear the flag, and the chain continues without the channel ever being disabled. A chain whose last descriptor links back to the first forms a ring.

Top module: `sg_chain_seq`

## Requirements
- R1: After reset the engine is idle: busy_o=0, mem_req_o=0, enable_o=0, stop_o=1, pkt_count_o=0, next_addr_o=0.
- R2: A descriptor at byte pointer P occupies memory words (P>>2)+0 (control), (P>>2)+1 (status) and (P>>2)+2 (link). The low two bits of P are ignored.
- R3: The link word of every processed descriptor is loaded into next_addr_o and then followed, so a chain that links back to its start wraps as a ring.
- R4: After the mover's done pulse, the status word is written with 32'h0000_0001: busy bit 31 cleared and done bit 0 set. Descriptors that are not processed keep their status.
- R5: Writing 0 to the enable register (reg_sel_i=1, bit 0) lets the descriptor in progress finish, and the engine then goes idle. enable_o reads 1 until busy_o falls.
- R6: Fetching starts only while the enable bit is 1 and the live stop flag is 0. Clearing the stop flag (reg_sel_i=2, bit 1 = 0) while enabled resumes at next_addr_o.
- R7: Each retired descriptor whose control bit 0 (last) is set increments pkt_count_o by one and gives a one-cycle pulse on pkt_done_o.
- R8: Writes to the next-pointer register (reg_sel_i=0) take effect only while busy_o=0.
- R9: Every memory access holds mem_req_o and mem_addr_o steady until mem_ack_i is seen.
- R10: Each descriptor produces exactly one single-cycle xfer_start_o, with xfer_ctrl_o equal to its control word.
- R11: A done pulse that arrives outside the wait-for-done phase has no effect.
- R12: A descriptor whose control bit 1 (stop) is set sets stop_o. The engine goes idle after retiring it, without fetching the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 next pointer, 1 enable, 2 live stop |
| reg_wdata_i | input | 32 | Register write data |
| next_addr_o | output | 32 | Live next-descriptor byte pointer |
| enable_o | output | 1 | Enable readback, held at 1 while still busy |
| stop_o | output | 1 | Live stop flag |
| pkt_count_o | output | CNT_W | Packets completed |
| pkt_done_o | output | 1 | One-cycle packet-completed event |
| busy_o | output | 1 | Engine not idle |
| mem_req_o | output | 1 | Descriptor memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | MEM_AW | Descriptor memory word address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| xfer_start_o | output | 1 | Launch pulse to the data mover |
| xfer_ctrl_o | output | 32 | Control word of the current descriptor |
| xfer_done_i | input | 1 | Data mover done pulse |

## Verification
The bench runs a five-descriptor ring from several start points. These cover a two-descriptor packet followed by a stop, a stop that lands on the wrap-around link, a single stopping descriptor and a start pointer with its low bits set. Together they separate correct link following, packet counting, status writeback and pointer truncation. Directed runs drop the enable bit in the middle of a chain, resume from a halted chain, write the pointer while busy and keep firing stray done pulses outside the wait phase. These runs separate a graceful stop from an abort, and a write that is ignored from one that is taken.

// File: rtl/sg_chain_pkg.sv
`timescale 1ns/1ps
package sg_chain_pkg;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_LINK = 2;

  localparam int unsigned CTRL_LAST = 0;
  localparam int unsigned CTRL_STOP = 1;

  localparam logic [1:0] SEL_NEXT = 2'd0;
  localparam logic [1:0] SEL_EN   = 2'd1;
  localparam logic [1:0] SEL_STOP = 2'd2;

  // busy bit 31 cleared, done bit 0 set
  localparam logic [WORD_W-1:0] WB_STATUS = 32'h0000_0001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_CTRL,
    ST_FETCH_NEXT,
    ST_XFER,
    ST_WAIT_DONE,
    ST_WRITEBACK
  } seq_state_e;
endpackage

// File: rtl/sg_chain_regs.sv
`timescale 1ns/1ps
module sg_chain_regs
  import sg_chain_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic              eng_active_i,
  input  logic              set_stop_i,
  input  logic              ld_next_i,
  input  logic [WORD_W-1:0] next_val_i,
  input  logic              pkt_end_i,
  output logic [WORD_W-1:0] next_ptr_o,
  output logic              run_ok_o,
  output logic              stop_o,
  output logic              en_rd_o,
  output logic [CNT_W-1:0]  pkt_cnt_o,
  output logic              pkt_done_o
);
  logic [WORD_W-1:0] next_q;
  logic              en_q;
  logic              stop_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pd_q;

  logic wr_next, wr_en, wr_stop;
  assign wr_next = reg_we_i && (reg_sel_i == SEL_NEXT);
  assign wr_en   = reg_we_i && (reg_sel_i == SEL_EN);
  assign wr_stop = reg_we_i && (reg_sel_i == SEL_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      en_q   <= 1'b0;
      stop_q <= 1'b1;
      cnt_q  <= '0;
      pd_q   <= 1'b0;
    end else begin
      if (ld_next_i)                    next_q <= next_val_i;
      else if (wr_next && !eng_active_i) next_q <= reg_wdata_i;
      if (wr_en) en_q <= reg_wdata_i[0];
      // engine-side set wins over a same-cycle software clear
      if (set_stop_i)   stop_q <= 1'b1;
      else if (wr_stop) stop_q <= reg_wdata_i[CTRL_STOP];
      pd_q <= pkt_end_i;
      if (pkt_end_i) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign next_ptr_o = next_q;
  assign run_ok_o   = en_q & ~stop_q;
  assign stop_o     = stop_q;
  assign en_rd_o    = en_q | eng_active_i;
  assign pkt_cnt_o  = cnt_q;
  assign pkt_done_o = pd_q;

  a_r7_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CNT_W'(1)) && pd_q));

  a_r8_next_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_active_i && !ld_next_i) |=> (next_q == $past(next_q)));

  a_r12_stop_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_stop_i |=> stop_q);
endmodule

// File: rtl/sg_chain_fsm.sv
`timescale 1ns/1ps
module sg_chain_fsm
  import sg_chain_pkg::*;
#(
  parameter int unsigned MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_ok_i,
  input  logic [MEM_AW-1:0] desc_idx_i,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              xfer_done_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              xfer_start_o,
  output logic [WORD_W-1:0] xfer_ctrl_o,
  output logic              active_o,
  output logic              set_stop_o,
  output logic              ld_next_o,
  output logic [WORD_W-1:0] next_val_o,
  output logic              pkt_end_o
);
  seq_state_e        state_q, state_d;
  logic [MEM_AW-1:0] base_q;
  logic [WORD_W-1:0] ctrl_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (run_ok_i)    state_d = ST_FETCH_CTRL;
      ST_FETCH_CTRL: if (mem_ack_i)   state_d = ST_FETCH_NEXT;
      ST_FETCH_NEXT: if (mem_ack_i)   state_d = ST_XFER;
      ST_XFER:                        state_d = ST_WAIT_DONE;
      ST_WAIT_DONE:  if (xfer_done_i) state_d = ST_WRITEBACK;
      ST_WRITEBACK:  if (mem_ack_i)   state_d = run_ok_i ? ST_FETCH_CTRL : ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      ctrl_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_FETCH_CTRL && state_q != ST_FETCH_CTRL) base_q <= desc_idx_i;
      if (state_q == ST_FETCH_CTRL && mem_ack_i) ctrl_q <= mem_rdata_i;
    end
  end

  logic [MEM_AW-1:0] ofs;
  always_comb begin
    unique case (state_q)
      ST_FETCH_NEXT: ofs = MEM_AW'(OFS_LINK);
      ST_WRITEBACK:  ofs = MEM_AW'(OFS_STAT);
      default:       ofs = MEM_AW'(OFS_CTRL);
    endcase
  end

  assign mem_req_o    = (state_q == ST_FETCH_CTRL) || (state_q == ST_FETCH_NEXT) ||
                        (state_q == ST_WRITEBACK);
  assign mem_we_o     = (state_q == ST_WRITEBACK);
  assign mem_addr_o   = base_q + ofs;
  assign mem_wdata_o  = WB_STATUS;
  assign xfer_start_o = (state_q == ST_XFER);
  assign xfer_ctrl_o  = ctrl_q;
  assign active_o     = (state_q != ST_IDLE);
  assign set_stop_o   = (state_q == ST_FETCH_CTRL) && mem_ack_i && mem_rdata_i[CTRL_STOP];
  assign ld_next_o    = (state_q == ST_FETCH_NEXT) && mem_ack_i;
  assign next_val_o   = mem_rdata_i;
  assign pkt_end_o    = (state_q == ST_WRITEBACK) && mem_ack_i && ctrl_q[CTRL_LAST];

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r6_idle_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !run_ok_i) |=> (state_q == ST_IDLE));

  a_r10_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);

  a_r11_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_DONE && !xfer_done_i) |=> (state_q == ST_WAIT_DONE));

  a_r11_wb_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITEBACK && $past(state_q) != ST_WRITEBACK) |->
      ($past(state_q) == ST_WAIT_DONE));
endmodule

// File: rtl/sg_chain_seq.sv
`timescale 1ns/1ps
module sg_chain_seq
  import sg_chain_pkg::*;
#(
  parameter int unsigned MEM_AW = 8,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       next_addr_o,
  output logic              enable_o,
  output logic              stop_o,
  output logic [CNT_W-1:0]  pkt_count_o,
  output logic              pkt_done_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              xfer_start_o,
  output logic [31:0]       xfer_ctrl_o,
  input  logic              xfer_done_i
);
  logic              active, set_stop, ld_next, pkt_end, run_ok;
  logic [WORD_W-1:0] next_val, next_ptr;

  sg_chain_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_sel_i    (reg_sel_i),
    .reg_wdata_i  (reg_wdata_i),
    .eng_active_i (active),
    .set_stop_i   (set_stop),
    .ld_next_i    (ld_next),
    .next_val_i   (next_val),
    .pkt_end_i    (pkt_end),
    .next_ptr_o   (next_ptr),
    .run_ok_o     (run_ok),
    .stop_o       (stop_o),
    .en_rd_o      (enable_o),
    .pkt_cnt_o    (pkt_count_o),
    .pkt_done_o   (pkt_done_o)
  );

  sg_chain_fsm #(.MEM_AW(MEM_AW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_ok_i     (run_ok),
    .desc_idx_i   (next_ptr[MEM_AW+1:2]),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .xfer_done_i  (xfer_done_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .xfer_start_o (xfer_start_o),
    .xfer_ctrl_o  (xfer_ctrl_o),
    .active_o     (active),
    .set_stop_o   (set_stop),
    .ld_next_o    (ld_next),
    .next_val_o   (next_val),
    .pkt_end_o    (pkt_end)
  );

  assign next_addr_o = next_ptr;
  assign busy_o      = active;

  a_r5_en_until_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> enable_o);
endmodule

// File: tb/sg_chain_seq_tb.sv
`timescale 1ns/1ps
module sg_chain_seq_tb_top;
  localparam int MEM_AW = 8;
  localparam int CNT_W  = 10;
  localparam int NV     = 5;

  localparam logic [31:0] V_START [NV] = '{32'd0, 32'd36, 32'd24, 32'd15, 32'd48};
  localparam logic [31:0] V_NEXT  [NV] = '{32'd36, 32'd0, 32'd36, 32'd36, 32'd0};
  localparam int          V_PKTS  [NV] = '{2, 1, 1, 2, 1};
  localparam logic [4:0]  V_MASK  [NV] = '{5'b00111, 5'b11000, 5'b00100, 5'b00110, 5'b10000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              reg_we = 1'b0;
  logic [1:0]        reg_sel = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       next_addr;
  logic              enable, stop, pkt_done, busy;
  logic [CNT_W-1:0]  pkt_count;
  logic              mem_req, mem_we, mem_ack;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0]       mem_wdata, mem_rdata;
  logic              xfer_start, xfer_done;
  logic [31:0]       xfer_ctrl;

  sg_chain_seq #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .next_addr_o(next_addr), .enable_o(enable), .stop_o(stop),
    .pkt_count_o(pkt_count), .pkt_done_o(pkt_done), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .xfer_start_o(xfer_start), .xfer_ctrl_o(xfer_ctrl), .xfer_done_i(xfer_done)
  );

  // descriptor memory, one-cycle acknowledge
  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  // stub data mover
  logic [3:0] mv_cnt;
  logic       mv_done;
  logic       stray_en = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mv_cnt  <= '0;
      mv_done <= 1'b0;
    end else begin
      mv_done <= (mv_cnt == 4'd1);
      if (xfer_start)       mv_cnt <= 4'd5;
      else if (mv_cnt != 0) mv_cnt <= mv_cnt - 4'd1;
    end
  end
  assign xfer_done = mv_done | (stray_en & (mem_req | ~busy));

  int n_start = 0, n_real = 0, n_wb = 0, n_pd = 0, n_stray = 0, cyc = 0;
  logic [31:0] last_ctrl = '0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (xfer_start) begin n_start++; last_ctrl <= xfer_ctrl; end
      if (mv_done) n_real++;
      if (mem_req && mem_we && mem_ack) n_wb++;
      if (pkt_done) n_pd++;
      if (stray_en & (mem_req | ~busy)) n_stray++;
    end
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // ring of five: D1,D2,D4 end packets; D2,D4 stop; D4 links to D0
  task automatic init_ring();
    for (int k = 0; k < 5; k++) begin
      mem[3*k]   = (k == 1) ? 32'h1 : (k == 2 || k == 4) ? 32'h3 : 32'h0;
      mem[3*k+1] = 32'h8000_0000;
      mem[3*k+2] = (k == 4) ? 32'd0 : 32'(12*(k+1));
    end
  endtask

  initial begin
    int base_cnt, base_pd;
    init_ring();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 enable", {31'b0, enable}, 32'd0);
    chk("R1 stop", {31'b0, stop}, 32'd1);
    chk("R1 count", 32'(pkt_count), 32'd0);
    chk("R1 next", next_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: stop cleared but enable off -> no fetch
    reg_write(2'd2, 32'h0);
    repeat (8) @(negedge clk);
    chk("R6 gated by enable", {31'b0, busy}, 32'd0);
    reg_write(2'd2, 32'h2);
    reg_write(2'd1, 32'h1);
    repeat (8) @(negedge clk);
    chk("R6 gated by stop", {31'b0, busy}, 32'd0);

    stray_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      init_ring();
      base_cnt = int'(pkt_count);
      base_pd  = n_pd;
      reg_write(2'd0, V_START[i]);
      reg_write(2'd2, 32'h0);
      wait_idle();
      chk($sformatf("R3 R2 next v%0d", i), next_addr, V_NEXT[i]);
      chk($sformatf("R7 count v%0d", i), 32'(int'(pkt_count) - base_cnt), 32'(V_PKTS[i]));
      chk($sformatf("R7 pulses v%0d", i), 32'(n_pd - base_pd), 32'(V_PKTS[i]));
      chk($sformatf("R12 stop v%0d", i), {31'b0, stop}, 32'd1);
      chk($sformatf("R10 ctrl v%0d", i), last_ctrl, 32'h3);
      for (int k = 0; k < 5; k++)
        chk($sformatf("R4 status v%0d d%0d", i, k), mem[3*k+1],
            V_MASK[i][k] ? 32'h1 : 32'h8000_0000);
    end

    // R5 graceful stop mid-chain
    init_ring();
    reg_write(2'd0, 32'd0);
    reg_write(2'd2, 32'h0);
    while (!xfer_start) @(negedge clk);
    reg_write(2'd1, 32'h0);
    chk("R5 enable reads 1 while busy", {30'b0, enable, busy}, 32'h3);
    wait_idle();
    chk("R5 enable after idle", {31'b0, enable}, 32'd0);
    chk("R5 next after stop", next_addr, 32'd12);
    chk("R5 d0 done", mem[1], 32'h1);
    chk("R5 d1 untouched", mem[4], 32'h8000_0000);
    chk("R5 stop clear", {31'b0, stop}, 32'd0);

    // R6 resume at current next pointer
    reg_write(2'd1, 32'h1);
    wait_idle();
    chk("R6 resume next", next_addr, 32'd36);
    chk("R6 resume d1", mem[4], 32'h1);
    chk("R6 resume d2", mem[7], 32'h1);

    // R8 pointer write ignored while busy
    init_ring();
    reg_write(2'd0, 32'd0);
    reg_write(2'd2, 32'h0);
    @(negedge clk); @(negedge clk);
    reg_write(2'd0, 32'd48);
    wait_idle();
    chk("R8 busy write ignored", next_addr, 32'd36);
    chk("R8 d4 untouched", mem[13], 32'h8000_0000);
    reg_write(2'd0, 32'd48);
    chk("R8 idle write taken", next_addr, 32'd48);

    // R11 stray done pulses ignored; R10 one start per descriptor
    stray_en = 1'b0;
    chk("R11 strays injected", {31'b0, (n_stray > 0)}, 32'd1);
    chk("R11 writebacks match real dones", 32'(n_wb), 32'(n_real));
    chk("R10 starts match real dones", 32'(n_start), 32'(n_real));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule